// File: doc/BRIEF.md
# Registered Command Buffer with Delayed Parity Check

This block sits on the address and command path of a memory module. On every rising clock edge it registers a wide data word and drives the result on two identical output buses, so that one input load feeds two banks of devices. Four active-low chip-select inputs travel with the word. When the gate-enable input is high and none of the chip selects is asserted, the output registers keep their values, which saves switching power on idle cycles.

The word is protected by a single parity bit that the controller sends one clock after the word it covers. The block keeps the parity of each captured word (data plus chip selects), combines it with the parity bit of the following cycle, and pulls an active-low error flag when the total count of ones is even. Once pulled low, the flag stays low for two clock cycles. A further error during that window starts the two cycles again. An asynchronous active-low reset clears all state at once. It overrides chip-select gating.

Top module: `cmd_reg_buffer`

## Requirements
- R1: When outputs are not gated, `q_a` equals the value that `d_in` had at the last rising clock edge.
- R2: `q_b` always equals `q_a`.
- R3: A word `{cs_n, d_in}` captured at edge k and `par_in` sampled at edge k+1 form an odd-parity check. If the count of ones over the 28 data bits, the 4 chip-select bits and the parity bit is even, `perr_n` is low after edge k+2.
- R4: After the last detected error, `perr_n` stays low for exactly two clock cycles and then returns high.
- R5: An error detected while `perr_n` is already low restarts the two-cycle low window.
- R6: While `rst_n` is low, `q_a` and `q_b` are zero and `perr_n` is high. This takes effect at once, without a clock edge.
- R7: When `gate_en` is 1 and `cs_n` is 4'b1111 at an edge, `q_a` and `q_b` keep their previous values.
- R8: When `gate_en` is 0, the outputs update at every edge whatever the value of `cs_n`.
- R9: Output gating has no effect on the parity check. A word captured while gated is still checked.
- R10: After reset is released, `par_in` at the first edge is ignored, because it has no captured word to pair with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge captures |
| rst_n | input | 1 | Asynchronous reset, active low |
| d_in | input | 28 | Data word |
| cs_n | input | 4 | Chip selects, active low, covered by parity |
| gate_en | input | 1 | Enables holding outputs when no chip select is low |
| par_in | input | 1 | Odd-parity bit for the word of the previous cycle |
| q_a | output | 28 | Registered copy A |
| q_b | output | 28 | Registered copy B |
| perr_n | output | 1 | Parity error flag, active low, held two cycles |

## Verification
Two conditions are hardest to reach from the ports. The first is a new error that lands inside a running two-cycle low window. The second is an error carried by a word captured while the outputs were frozen. Both need the parity bit to be wrong one cycle after a chosen word. The bench therefore tracks the parity of the word it drove last and chooses a correct or wrong parity bit deliberately. Directed sequences drive wrong bits on back-to-back cycles and on gated cycles. The random phase skews chip selects toward all-deasserted and injects errors often enough to hit overlapping windows.

// File: rtl/cmd_reg_buffer.sv
module cmd_reg_buffer #(
  parameter int W    = 28,
  parameter int NCS  = 4,
  parameter int HOLD = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   d_in,
  input  logic [NCS-1:0] cs_n,
  input  logic           gate_en,
  input  logic           par_in,
  output logic [W-1:0]   q_a,
  output logic [W-1:0]   q_b,
  output logic           perr_n
);
  localparam int CW = $clog2(HOLD + 1);

  logic          freeze;
  logic          word_par;
  logic          pw, v1, v2, ok;
  logic          err;
  logic [CW-1:0] cnt;

  assign freeze   = gate_en & (&cs_n);
  assign word_par = ^{cs_n, d_in};
  assign err      = v2 & ~ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_a <= '0;
    else if (!freeze) q_a <= d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_b <= '0;
    else if (!freeze) q_b <= d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw <= 1'b0;
      v1 <= 1'b0;
      v2 <= 1'b0;
      ok <= 1'b1;
    end else begin
      pw <= word_par;
      v1 <= 1'b1;
      ok <= pw ^ par_in;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_n <= 1'b1;
      cnt    <= '0;
    end else if (err) begin
      perr_n <= 1'b0;
      cnt    <= CW'(HOLD - 1);
    end else if (cnt != '0) begin
      cnt    <= cnt - 1'b1;
    end else begin
      perr_n <= 1'b1;
    end
  end
endmodule

module cmd_reg_buffer_chk #(
  parameter int W   = 28,
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [W-1:0]   d_in,
  input logic [NCS-1:0] cs_n,
  input logic           gate_en,
  input logic [W-1:0]   q_a,
  input logic [W-1:0]   q_b,
  input logic           perr_n
);
  p_update_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en && (&cs_n)) |=> (q_a == $past(d_in)));

  p_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_a == q_b);

  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_n) |=> !perr_n);

  p_reset_r6: assert property (@(posedge clk)
    !rst_n |-> (q_a == '0 && q_b == '0 && perr_n));

  p_gate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (&cs_n)) |=> ($stable(q_a) && $stable(q_b)));
endmodule

bind cmd_reg_buffer cmd_reg_buffer_chk #(.W(W), .NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .d_in(d_in), .cs_n(cs_n), .gate_en(gate_en),
  .q_a(q_a), .q_b(q_b), .perr_n(perr_n)
);

// File: tb/cmd_reg_buffer_bench.sv
module cmd_reg_buffer_bench;
  localparam int HOLD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [27:0] d_in = '0;
  logic [3:0]  cs_n = 4'h0;
  logic        gate_en = 1'b0;
  logic        par_in = 1'b0;
  logic [27:0] q_a, q_b;
  logic        perr_n;

  int checks = 0;
  int errors = 0;

  logic [27:0] m_q;
  logic        m_pw, m_v1, m_v2, m_ok, m_flag;
  int          m_cnt;
  logic        last_wpar;

  always #10 clk = ~clk;

  cmd_reg_buffer u_cmd_reg_buffer (
    .clk(clk), .rst_n(rst_n), .d_in(d_in), .cs_n(cs_n), .gate_en(gate_en),
    .par_in(par_in), .q_a(q_a), .q_b(q_b), .perr_n(perr_n)
  );

  function automatic logic odd_bit(input logic [3:0] cs, input logic [27:0] d);
    return ~(^{cs, d});
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_q = '0; m_pw = 1'b0; m_v1 = 1'b0; m_v2 = 1'b0; m_ok = 1'b1;
    m_flag = 1'b1; m_cnt = 0; last_wpar = 1'b0;
  endtask

  task automatic step(input logic [27:0] d, input logic [3:0] cs, input logic ge,
                      input logic bad, input string qtag, input string ftag);
    par_in  = bad ? ~last_wpar : last_wpar;
    d_in    = d;
    cs_n    = cs;
    gate_en = ge;
    @(posedge clk);
    if (m_v2 && !m_ok) begin m_flag = 1'b0; m_cnt = HOLD - 1; end
    else if (m_cnt != 0) m_cnt--;
    else m_flag = 1'b1;
    m_ok = m_pw ^ par_in;
    m_v2 = m_v1;
    m_pw = ^{cs, d};
    m_v1 = 1'b1;
    if (!(ge && (&cs))) m_q = d;
    last_wpar = odd_bit(cs, d);
    @(negedge clk);
    chk(qtag, {4'h0, q_a}, {4'h0, m_q});
    chk("R2", {4'h0, q_b}, {4'h0, m_q});
    chk(ftag, {31'h0, perr_n}, {31'h0, m_flag});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6", {4'h0, q_a}, 32'h0);
    chk("R6", {31'h0, perr_n}, 32'h1);
    rst_n = 1'b1;

    // R10: first parity bit after reset has no word to pair with
    step(28'h0000001, 4'h0, 1'b0, 1'b1, "R1", "R10");
    step(28'h00000F3, 4'h2, 1'b0, 1'b0, "R1", "R10");
    step(28'h1234567, 4'h0, 1'b0, 1'b0, "R1", "R10");
    step(28'h0ABCDEF, 4'h5, 1'b0, 1'b0, "R1", "R10");

    // R3 and R4: one error, flag low exactly two cycles
    step(28'h0000003, 4'h0, 1'b0, 1'b1, "R1", "R3");
    step(28'h0000007, 4'h0, 1'b0, 1'b0, "R1", "R3");
    step(28'h000000F, 4'h0, 1'b0, 1'b0, "R1", "R4");
    step(28'h000001F, 4'h0, 1'b0, 1'b0, "R1", "R4");
    step(28'h000003F, 4'h0, 1'b0, 1'b0, "R1", "R4");
    chk("R4", {31'h0, perr_n}, 32'h1);

    // R5: error inside the window restarts the hold
    step(28'h0111111, 4'h1, 1'b0, 1'b1, "R1", "R3");
    step(28'h0222222, 4'h1, 1'b0, 1'b0, "R1", "R3");
    step(28'h0333333, 4'h1, 1'b0, 1'b1, "R1", "R5");
    step(28'h0444444, 4'h1, 1'b0, 1'b0, "R1", "R5");
    step(28'h0555555, 4'h1, 1'b0, 1'b0, "R1", "R5");
    step(28'h0666666, 4'h1, 1'b0, 1'b0, "R1", "R5");
    step(28'h0777777, 4'h1, 1'b0, 1'b0, "R1", "R5");

    // R7: gated hold
    step(28'hAAAAAAA, 4'h0, 1'b1, 1'b0, "R1", "R3");
    step(28'h5555555, 4'hF, 1'b1, 1'b0, "R7", "R3");
    step(28'h0F0F0F0, 4'hF, 1'b1, 1'b0, "R7", "R3");
    chk("R7", {4'h0, q_a}, 32'hAAAAAAA);
    // R8: gate disabled, all deasserted still updates
    step(28'h0C0FFEE, 4'hF, 1'b0, 1'b0, "R8", "R3");
    chk("R8", {4'h0, q_a}, 32'h0C0FFEE);
    // R9: error on a word captured while gated
    step(28'h1111111, 4'hF, 1'b1, 1'b0, "R7", "R9");
    step(28'h2222222, 4'hF, 1'b1, 1'b1, "R7", "R9");
    step(28'h3333333, 4'hF, 1'b1, 1'b0, "R7", "R9");
    chk("R9", {31'h0, perr_n}, 32'h0);
    step(28'h4444444, 4'hF, 1'b1, 1'b0, "R7", "R9");

    // R6: asynchronous reset mid-cycle while flag low
    step(28'h0000011, 4'h0, 1'b0, 1'b1, "R1", "R3");
    step(28'h0000022, 4'h0, 1'b0, 1'b0, "R1", "R3");
    step(28'h0000033, 4'h0, 1'b0, 1'b0, "R1", "R3");
    #5 rst_n = 1'b0;
    #1;
    chk("R6", {4'h0, q_a}, 32'h0);
    chk("R6", {4'h0, q_b}, 32'h0);
    chk("R6", {31'h0, perr_n}, 32'h1);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] cs;
      cs = ($urandom % 3 == 0) ? 4'hF : 4'($urandom);
      step(28'($urandom), cs, 1'($urandom), ($urandom % 6 == 0), "R1", "R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule